// File: doc/BRIEF.md
# Two-Bank Alternating Register File

This block is the shared data register file of one processing cluster. Two execution units use it: a load/store unit and an arithmetic unit. The sixteen registers are split evenly into two banks. In any cycle each unit works inside exactly one bank, and the two units always work in opposite banks. As a result, each bank needs only the ports of a single unit: two reads and one write. It never needs the ports of both units at once.

Every cycle the block looks at the requests from both units. It works out which bank each unit wants and settles a single switcher state for that cycle, which records the bank the load/store unit holds. It then steers each bank's ports to the unit that owns that bank. When the requests of a cycle cannot be served under the bank rules, the block raises a conflict flag for that cycle, drops every write of the bundle and returns zero on every read. The scheduler upstream uses this to reject the bundle. Reads are combinational and writes commit at the clock edge.

Top module: `pingpong_regfile`

## Requirements
- R1: After a synchronous active-low reset, every register reads as zero and the switcher state is 0.
- R2: Register index bit 3 selects the bank: indices 0-7 are in bank 0 and 8-15 are in bank 1. A value written without conflict is returned by later reads of the same index from whichever unit reads it.
- R3: If the enabled accesses of one unit (either read port or the write port) name registers in both banks, the conflict output is high in that cycle.
- R4: If both units have at least one enabled access and every access falls in the same single bank, the conflict output is high in that cycle.
- R5: In a conflict cycle, neither unit's write changes any register, and the switcher state keeps its value.
- R6: In a cycle without conflict, the switcher state after the edge equals the bank of the load/store unit when that unit is active. When only the arithmetic unit is active, it equals the bank opposite to the arithmetic unit's bank.
- R7: In a cycle where neither unit has an enabled access, the switcher state keeps its value.
- R8: A read of a register that is being written in the same cycle returns the value held before that cycle.
- R9: The read data of a disabled read port is zero, and in a conflict cycle all read data are zero.
- R10: Without conflict, the load/store write and the arithmetic write to opposite banks both commit at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ls_rd_en | input | 2 | Load/store read port enables |
| ls_rd_idx | input | 2x4 | Load/store read register indices |
| ls_rd_data | output | 2x32 | Load/store read data |
| ls_wr_en | input | 1 | Load/store write enable |
| ls_wr_idx | input | 4 | Load/store write register index |
| ls_wr_data | input | 32 | Load/store write data |
| ar_rd_en | input | 2 | Arithmetic read port enables |
| ar_rd_idx | input | 2x4 | Arithmetic read register indices |
| ar_rd_data | output | 2x32 | Arithmetic read data |
| ar_wr_en | input | 1 | Arithmetic write enable |
| ar_wr_idx | input | 4 | Arithmetic write register index |
| ar_wr_data | input | 32 | Arithmetic write data |
| conflict | output | 1 | Bundle breaks the bank rules in this cycle |
| sw_state | output | 1 | Switcher state: bank held by the load/store unit |

## Verification
The bench sweeps all 256 pairs of write indices from the two units. The same-bank pairs must raise the conflict flag and leave both registers untouched, and a design that gated only one unit's write would leave a stray value behind. Splits inside one unit are mixed into a long stream of mostly legal bundles, including splits that appear only between a read port and the write port. A design that checked only the reads would let such a write corrupt the other bank. Idle cycles and cycles with only the arithmetic unit active test the switcher. A design that cleared the state on idle cycles, or copied the arithmetic bank without inverting it, would steer the next bundle to the wrong bank. Reads of a register in the cycle it is written must show the old value, so a write-through bypass would be caught.

// File: rtl/pp_rf_pkg.sv
// Package: shared types for the two-bank alternating register file.
package pp_rf_pkg;
    localparam int unsigned PP_NUM_BANKS = 2;

    // Summary of which banks one unit touches in the current cycle.
    typedef struct packed {
        logic active;   // at least one enabled access
        logic split;    // accesses in both banks
        logic bank;     // bank used (meaningful when active and not split)
    } bank_use_t;
endpackage

// File: rtl/pp_unit_bank.sv
// Module: pp_unit_bank
// Summarizes the bank footprint of one execution unit in the current cycle.
// Assumes the bank is the most significant bit of the register index.
module pp_unit_bank #(
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned NUM_RD = 2
) (
    input  logic [NUM_RD-1:0]            rd_en,
    input  logic [NUM_RD-1:0][IDX_W-1:0] rd_idx,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    output pp_rf_pkg::bank_use_t         use_o
);
    logic touch0;
    logic touch1;

    // Collect the banks named by every enabled access of this unit.
    always_comb begin
        touch0 = 1'b0;
        touch1 = 1'b0;
        for (int p = 0; p < NUM_RD; p++) begin
            if (rd_en[p]) begin
                if (rd_idx[p][IDX_W-1]) touch1 = 1'b1;
                else                    touch0 = 1'b1;
            end
        end
        if (wr_en) begin
            if (wr_idx[IDX_W-1]) touch1 = 1'b1;
            else                 touch0 = 1'b1;
        end
        use_o.active = touch0 | touch1;
        use_o.split  = touch0 & touch1;
        use_o.bank   = touch1;
    end
endmodule

// File: rtl/pp_switcher.sv
// Module: pp_switcher
// Checks the bank rules for one bundle and holds the switcher state.
// The state names the bank owned by the load/store unit; the arithmetic unit
// owns the other one. Assumes a synchronous active-low reset.
module pp_switcher (
    input  logic                 clk,
    input  logic                 rst_n,
    input  pp_rf_pkg::bank_use_t ls_use,
    input  pp_rf_pkg::bank_use_t ar_use,
    output logic                 conflict,
    output logic                 sel_now,
    output logic                 sw_state
);
    // Rule check: one bank per unit, and opposite banks for the two units.
    always_comb begin
        conflict = ls_use.split | ar_use.split |
                   (ls_use.active & ar_use.active & (ls_use.bank == ar_use.bank));
    end

    // Bank ownership for this cycle, derived from whichever unit is active.
    always_comb begin
        if (ls_use.active)      sel_now = ls_use.bank;
        else if (ar_use.active) sel_now = ~ar_use.bank;
        else                    sel_now = sw_state;
    end

    // State register: updated only by a legal, non-idle bundle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sw_state <= 1'b0;
        else if (!conflict && (ls_use.active || ar_use.active))
            sw_state <= sel_now;
    end
endmodule

// File: rtl/pp_bank.sv
// Module: pp_bank
// One register bank with NUM_RD combinational read ports and one write port.
// Writes commit at the clock edge, so same-cycle reads see the old value.
module pp_bank #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned NUM_RD = 2,
    localparam int unsigned LOC_W = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_RD-1:0][LOC_W-1:0]  rd_idx,
    output logic [NUM_RD-1:0][DATA_W-1:0] rd_data,
    input  logic                          we,
    input  logic [LOC_W-1:0]              wr_idx,
    input  logic [DATA_W-1:0]             wr_data
);
    logic [DATA_W-1:0] cells [DEPTH];

    // Storage: clear on reset, otherwise accept the single write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[wr_idx] <= wr_data;
        end
    end

    // Read ports: plain combinational lookups.
    always_comb begin
        for (int p = 0; p < NUM_RD; p++) rd_data[p] = cells[rd_idx[p]];
    end
endmodule

// File: rtl/pingpong_regfile.sv
// Module: pingpong_regfile (top)
// Shared data register file split into two banks. The load/store unit and
// the arithmetic unit each use one bank per cycle, on opposite banks, so each
// bank carries the ports of only one unit. Illegal bundles raise conflict,
// lose all their writes and read back zero.
module pingpong_regfile #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned NUM_RD   = 2,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS),
    localparam int unsigned LOC_W   = IDX_W - 1,
    localparam int unsigned DEPTH   = NUM_REGS / pp_rf_pkg::PP_NUM_BANKS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_RD-1:0]             ls_rd_en,
    input  logic [NUM_RD-1:0][IDX_W-1:0]  ls_rd_idx,
    output logic [NUM_RD-1:0][DATA_W-1:0] ls_rd_data,
    input  logic                          ls_wr_en,
    input  logic [IDX_W-1:0]              ls_wr_idx,
    input  logic [DATA_W-1:0]             ls_wr_data,
    input  logic [NUM_RD-1:0]             ar_rd_en,
    input  logic [NUM_RD-1:0][IDX_W-1:0]  ar_rd_idx,
    output logic [NUM_RD-1:0][DATA_W-1:0] ar_rd_data,
    input  logic                          ar_wr_en,
    input  logic [IDX_W-1:0]              ar_wr_idx,
    input  logic [DATA_W-1:0]             ar_wr_data,
    output logic                          conflict,
    output logic                          sw_state
);
    pp_rf_pkg::bank_use_t ls_use;
    pp_rf_pkg::bank_use_t ar_use;
    logic                 sel_now;
    logic [NUM_RD-1:0][DATA_W-1:0] bank_rd [pp_rf_pkg::PP_NUM_BANKS];

    pp_unit_bank #(.IDX_W(IDX_W), .NUM_RD(NUM_RD)) u_ls_use (
        .rd_en(ls_rd_en), .rd_idx(ls_rd_idx), .wr_en(ls_wr_en),
        .wr_idx(ls_wr_idx), .use_o(ls_use)
    );

    pp_unit_bank #(.IDX_W(IDX_W), .NUM_RD(NUM_RD)) u_ar_use (
        .rd_en(ar_rd_en), .rd_idx(ar_rd_idx), .wr_en(ar_wr_en),
        .wr_idx(ar_wr_idx), .use_o(ar_use)
    );

    pp_switcher u_switch (
        .clk(clk), .rst_n(rst_n), .ls_use(ls_use), .ar_use(ar_use),
        .conflict(conflict), .sel_now(sel_now), .sw_state(sw_state)
    );

    // Per-bank port steering: the owning unit drives the bank's ports.
    for (genvar b = 0; b < pp_rf_pkg::PP_NUM_BANKS; b++) begin : g_bank
        logic                         own_ls;
        logic [NUM_RD-1:0][LOC_W-1:0] rd_loc;
        logic                         wr_sel_en;
        logic [IDX_W-1:0]             wr_sel_idx;
        logic [DATA_W-1:0]            wr_sel_data;
        logic                         we;

        assign own_ls      = (sel_now == 1'(b));
        assign wr_sel_en   = own_ls ? ls_wr_en   : ar_wr_en;
        assign wr_sel_idx  = own_ls ? ls_wr_idx  : ar_wr_idx;
        assign wr_sel_data = own_ls ? ls_wr_data : ar_wr_data;
        assign we = !conflict && wr_sel_en && (wr_sel_idx[IDX_W-1] == 1'(b));

        for (genvar p = 0; p < NUM_RD; p++) begin : g_rport
            assign rd_loc[p] = own_ls ? ls_rd_idx[p][LOC_W-1:0]
                                      : ar_rd_idx[p][LOC_W-1:0];
        end

        pp_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH), .NUM_RD(NUM_RD)) u_bank (
            .clk(clk), .rst_n(rst_n), .rd_idx(rd_loc), .rd_data(bank_rd[b]),
            .we(we), .wr_idx(wr_sel_idx[LOC_W-1:0]), .wr_data(wr_sel_data)
        );
    end

    // Return path: each unit reads from its own bank, zero when blocked.
    for (genvar p = 0; p < NUM_RD; p++) begin : g_ret
        assign ls_rd_data[p] = (ls_rd_en[p] && !conflict)
                               ? bank_rd[ls_rd_idx[p][IDX_W-1]][p] : '0;
        assign ar_rd_data[p] = (ar_rd_en[p] && !conflict)
                               ? bank_rd[ar_rd_idx[p][IDX_W-1]][p] : '0;
    end
endmodule

// File: rtl/pp_regfile_chk.sv
// Module: pp_regfile_chk
// Property checker for pingpong_regfile, attached by bind. Recomputes each
// unit's bank footprint from the ports and relates it to conflict and state.
module pp_regfile_chk #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned NUM_RD   = 2,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_RD-1:0]             ls_rd_en,
    input logic [NUM_RD-1:0][IDX_W-1:0]  ls_rd_idx,
    input logic [NUM_RD-1:0][DATA_W-1:0] ls_rd_data,
    input logic                          ls_wr_en,
    input logic [IDX_W-1:0]              ls_wr_idx,
    input logic [DATA_W-1:0]             ls_wr_data,
    input logic [NUM_RD-1:0]             ar_rd_en,
    input logic [NUM_RD-1:0][IDX_W-1:0]  ar_rd_idx,
    input logic [NUM_RD-1:0][DATA_W-1:0] ar_rd_data,
    input logic                          ar_wr_en,
    input logic [IDX_W-1:0]              ar_wr_idx,
    input logic [DATA_W-1:0]             ar_wr_data,
    input logic                          conflict,
    input logic                          sw_state
);
    logic ls_lo, ls_hi, ar_lo, ar_hi;
    logic ls_act, ar_act;

    // Footprint of each unit as seen at the ports.
    always_comb begin
        ls_lo = ls_wr_en && !ls_wr_idx[IDX_W-1];
        ls_hi = ls_wr_en &&  ls_wr_idx[IDX_W-1];
        ar_lo = ar_wr_en && !ar_wr_idx[IDX_W-1];
        ar_hi = ar_wr_en &&  ar_wr_idx[IDX_W-1];
        for (int p = 0; p < NUM_RD; p++) begin
            ls_lo = ls_lo | (ls_rd_en[p] && !ls_rd_idx[p][IDX_W-1]);
            ls_hi = ls_hi | (ls_rd_en[p] &&  ls_rd_idx[p][IDX_W-1]);
            ar_lo = ar_lo | (ar_rd_en[p] && !ar_rd_idx[p][IDX_W-1]);
            ar_hi = ar_hi | (ar_rd_en[p] &&  ar_rd_idx[p][IDX_W-1]);
        end
        ls_act = ls_lo | ls_hi;
        ar_act = ar_lo | ar_hi;
    end

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (sw_state == 1'b0));

    a_r3_split_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ((ls_lo && ls_hi) || (ar_lo && ar_hi)) |-> conflict);

    a_r4_same_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_act && ar_act && (ls_lo == ar_lo) && (ls_hi == ar_hi)) |-> conflict);

    a_r5_conflict_hold: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |=> $stable(sw_state));

    a_r6_state_from_ls: assert property (@(posedge clk) disable iff (!rst_n)
        (!conflict && ls_act) |=> (sw_state == $past(ls_hi)));

    a_r6_state_from_ar: assert property (@(posedge clk) disable iff (!rst_n)
        (!conflict && !ls_act && ar_act) |=> (sw_state == !$past(ar_hi)));

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ls_act && !ar_act) |=> $stable(sw_state));

    a_r9_conflict_zero: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> (ls_rd_data == '0 && ar_rd_data == '0));
endmodule

bind pingpong_regfile pp_regfile_chk #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_RD(NUM_RD)
) u_chk (.*);

// File: tb/test_pingpong_regfile.sv
// Bench for pingpong_regfile: directed corner cases, an exhaustive sweep of
// write-index pairs, and a long stream of mostly legal bundles, all checked
// against a reference model computed from the requirements.
module test_pingpong_regfile;
    localparam int DW = 32;
    localparam int NR = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      ls_rd_en, ar_rd_en;
    logic [1:0][3:0] ls_rd_idx, ar_rd_idx;
    logic [1:0][DW-1:0] ls_rd_data, ar_rd_data;
    logic            ls_wr_en, ar_wr_en;
    logic [3:0]      ls_wr_idx, ar_wr_idx;
    logic [DW-1:0]   ls_wr_data, ar_wr_data;
    logic            conflict, sw_state;

    int              n_cmp = 0;
    int              n_bad = 0;
    logic [DW-1:0]   model [NR];
    logic            exp_state;

    always #5 clk = ~clk;

    pingpong_regfile i_pingpong_regfile (
        .clk(clk), .rst_n(rst_n),
        .ls_rd_en(ls_rd_en), .ls_rd_idx(ls_rd_idx), .ls_rd_data(ls_rd_data),
        .ls_wr_en(ls_wr_en), .ls_wr_idx(ls_wr_idx), .ls_wr_data(ls_wr_data),
        .ar_rd_en(ar_rd_en), .ar_rd_idx(ar_rd_idx), .ar_rd_data(ar_rd_data),
        .ar_wr_en(ar_wr_en), .ar_wr_idx(ar_wr_idx), .ar_wr_data(ar_wr_data),
        .conflict(conflict), .sw_state(sw_state)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle();
        ls_rd_en = '0; ar_rd_en = '0; ls_wr_en = 1'b0; ar_wr_en = 1'b0;
        ls_rd_idx = '0; ar_rd_idx = '0; ls_wr_idx = '0; ar_wr_idx = '0;
        ls_wr_data = '0; ar_wr_data = '0;
    endtask

    // One bundle: inputs are already set (after a falling edge).
    task automatic cyc(input string tag);
        logic l0, l1, a0, a1, la, aa, cf;
        logic [DW-1:0] e;
        #1;
        l0 = ls_wr_en && !ls_wr_idx[3]; l1 = ls_wr_en && ls_wr_idx[3];
        a0 = ar_wr_en && !ar_wr_idx[3]; a1 = ar_wr_en && ar_wr_idx[3];
        for (int p = 0; p < 2; p++) begin
            if (ls_rd_en[p]) begin if (ls_rd_idx[p][3]) l1 = 1'b1; else l0 = 1'b1; end
            if (ar_rd_en[p]) begin if (ar_rd_idx[p][3]) a1 = 1'b1; else a0 = 1'b1; end
        end
        la = l0 | l1; aa = a0 | a1;
        cf = (l0 & l1) | (a0 & a1) | (la & aa & (l1 == a1) & !(l0 & l1) & !(a0 & a1));
        check({tag, " R3/R4 conflict"}, DW'(conflict), DW'(cf));
        for (int p = 0; p < 2; p++) begin
            e = (ls_rd_en[p] && !cf) ? model[ls_rd_idx[p]] : '0;
            check({tag, (e == '0) ? " R9 ls read" : " R2/R8 ls read"}, ls_rd_data[p], e);
            e = (ar_rd_en[p] && !cf) ? model[ar_rd_idx[p]] : '0;
            check({tag, (e == '0) ? " R9 ar read" : " R2/R8 ar read"}, ar_rd_data[p], e);
        end
        @(posedge clk);
        if (!cf) begin
            if (ls_wr_en) model[ls_wr_idx] = ls_wr_data;
            if (ar_wr_en) model[ar_wr_idx] = ar_wr_data;
            if (la) exp_state = l1;
            else if (aa) exp_state = !a1;
        end
        @(negedge clk);
        check({tag, " R5/R6/R7 state"}, DW'(sw_state), DW'(exp_state));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NR; i++) model[i] = '0;
        exp_state = 1'b0;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 state after reset", DW'(sw_state), '0);

        // R1: every register reads zero, pairs within one bank.
        for (int k = 0; k < 8; k++) begin
            idle();
            ls_rd_en = 2'b11;
            ls_rd_idx[0] = 4'(2 * k); ls_rd_idx[1] = 4'(2 * k + 1);
            cyc("R1 cleared");
        end

        // R10 and R6: ls writes bank 1 while ar writes bank 0.
        idle();
        ls_wr_en = 1'b1; ls_wr_idx = 4'd8; ls_wr_data = 32'hAAAA_0008;
        ar_wr_en = 1'b1; ar_wr_idx = 4'd0; ar_wr_data = 32'hBBBB_0000;
        cyc("R10 dual write");
        check("R6 ls on bank 1", DW'(sw_state), 1);
        idle();
        ls_rd_en = 2'b01; ls_rd_idx[0] = 4'd8;
        ar_rd_en = 2'b01; ar_rd_idx[0] = 4'd0;
        cyc("R10 readback");

        // R4 and R5: load into D2 beside arithmetic on D0/D1.
        idle();
        ls_wr_en = 1'b1; ls_wr_idx = 4'd2; ls_wr_data = 32'hDEAD_0002;
        ar_rd_en = 2'b11; ar_rd_idx[0] = 4'd0; ar_rd_idx[1] = 4'd1;
        ar_wr_en = 1'b1; ar_wr_idx = 4'd1; ar_wr_data = 32'hDEAD_0001;
        cyc("R4 same bank");
        idle();
        ls_rd_en = 2'b11; ls_rd_idx[0] = 4'd2; ls_rd_idx[1] = 4'd1;
        cyc("R5 writes dropped");

        // R3 and R9: one unit reads both banks.
        idle();
        ls_rd_en = 2'b11; ls_rd_idx[0] = 4'd0; ls_rd_idx[1] = 4'd9;
        cyc("R3 read split");
        // R3: read in bank 0, write in bank 1 for the same unit.
        idle();
        ar_rd_en = 2'b01; ar_rd_idx[0] = 4'd0;
        ar_wr_en = 1'b1; ar_wr_idx = 4'd12; ar_wr_data = 32'h1234_5678;
        cyc("R3 write split");

        // R6: only ar active on bank 1 gives state 0; then R7 idle hold.
        idle();
        ar_rd_en = 2'b01; ar_rd_idx[0] = 4'd8;
        cyc("R6 ar only");
        idle();
        ar_rd_en = 2'b01; ar_rd_idx[0] = 4'd0;
        cyc("R6 ar only bank0");
        idle();
        cyc("R7 idle");
        cyc("R7 idle again");

        // R8: read and write of D3 in one cycle return the old value.
        idle();
        ls_wr_en = 1'b1; ls_wr_idx = 4'd3; ls_wr_data = 32'h0303_0303;
        ls_rd_en = 2'b01; ls_rd_idx[0] = 4'd3;
        cyc("R8 first write");
        ls_wr_data = 32'h3030_3030;
        cyc("R8 overwrite");

        // Exhaustive write-index pairs (R2, R4, R5, R10).
        for (int i = 0; i < NR; i++) begin
            for (int j = 0; j < NR; j++) begin
                idle();
                ls_wr_en = 1'b1; ls_wr_idx = 4'(i); ls_wr_data = 32'(i * 1000 + j);
                ar_wr_en = 1'b1; ar_wr_idx = 4'(j); ar_wr_data = 32'(j * 77 + i + 5);
                cyc("R10 pair sweep");
            end
        end

        // Mostly legal random bundles with injected splits and clashes.
        for (int n = 0; n < 3000; n++) begin
            logic lb, ab;
            lb = 1'($urandom);
            ab = ($urandom % 8 == 0) ? lb : !lb;
            ls_rd_en = 2'($urandom); ar_rd_en = 2'($urandom);
            ls_wr_en = 1'($urandom); ar_wr_en = 1'($urandom);
            for (int p = 0; p < 2; p++) begin
                ls_rd_idx[p] = {lb, 3'($urandom)};
                ar_rd_idx[p] = {ab, 3'($urandom)};
            end
            ls_wr_idx = {lb, 3'($urandom)}; ar_wr_idx = {ab, 3'($urandom)};
            if ($urandom % 16 == 0) ls_wr_idx[3] = !lb;
            if ($urandom % 16 == 0) ar_rd_idx[1][3] = !ab;
            ls_wr_data = $urandom; ar_wr_data = $urandom;
            cyc("R2 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule